// File: doc/BRIEF.md
# Per-Bit Mask Readiness Scoreboard

This block records, for a small set of integer registers that serve as vector masks, which individual mask bits still wait on a write. A producer that dispatches an operation names a register and a contiguous bit range (start bit and bit count), and those bits become pending. When the producer finishes, it reports the same register and range, and the bits are cleared. Consumers present a register and a bit range and receive a combinational ready flag. Because readiness is held per bit, a masked floating-point slice covering lanes 4k..4k+3 may start as soon as the compare and the mask-combine for those four lanes are done, while later lanes are still in flight. This chains a SIMD compare, a scalar AND-with-complement, and a masked SIMD add. Without it, the add would stall until the whole 64-bit register had settled.

A mode pin switches to whole-register tracking. A consumer is then ready only when no bit of the register is pending, which reproduces the slower unchained schedule. The dispatch and finish ports are valid-only event strobes. The scoreboard accepts every strobe in the cycle it is presented, so it never applies back-pressure and has no ready signal on those ports. A consumer holds its query for as long as it wants an answer. A vector-length input marks which mask bits exist. In per-bit mode, bits at or above it never block a consumer.

Top module: `mask_chain_scoreboard`

## Requirements
- R1: After reset no bit of any tracked register is pending, so every query reports ready in either mode.
- R2: A dispatch strobe with register r, start s and count n marks bits s..s+n-1 of r pending from the next cycle. Bits above 63 are dropped, and n = 0 marks nothing.
- R3: A finish strobe with register r, start s and count n clears bits s..s+n-1 of r from the next cycle. Other registers and bits are untouched.
- R4: When a dispatch and a finish cover the same bits of the same register in one cycle, the finish is applied first and the dispatch second, so those bits end up pending.
- R5: In per-bit mode (whole_mode = 0), a query is ready exactly when none of the bits it names that lie below vlen is pending. The answer is combinational on the stored state, so a finish in cycle c unblocks a consumer in cycle c+1.
- R6: In per-bit mode, query bits at index vlen or above are treated as ready even when they are pending.
- R7: In whole-register mode (whole_mode = 1), a query is ready only when all 64 bits of its register are clear, whatever range it names.
- R8: Several dispatch and finish ports may act in the same cycle, on the same register or on different ones. Their effects combine bit by bit.
- R9: In a run of vlen = 20 where compare slice k finishes in cycle k, the combine slice and then the masked add slice follow as early as the scoreboard allows. In per-bit mode the add slices run in cycles 2 to 6. In whole-register mode the combine runs once in cycle 5 and the add slices run in cycles 6 to 10. No add slice runs before or in the cycle in which its combine finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| whole_mode | input | 1 | 1: whole-register tracking, 0: per-bit tracking |
| vlen | input | 7 | Number of valid mask bits (0 to 64) |
| iss_valid | input | 2 | Dispatch strobe, one per port |
| iss_reg | input | 2x2 | Register written by each dispatch |
| iss_start | input | 2x6 | First bit of each dispatch range |
| iss_cnt | input | 2x7 | Bit count of each dispatch range |
| cmp_valid | input | 2 | Finish strobe, one per port |
| cmp_reg | input | 2x2 | Register written by each finish |
| cmp_start | input | 2x6 | First bit of each finish range |
| cmp_cnt | input | 2x7 | Bit count of each finish range |
| q_reg | input | 3x2 | Register read by each consumer query |
| q_start | input | 3x6 | First bit of each query range |
| q_cnt | input | 3x7 | Bit count of each query range |
| q_ready | output | 3 | Query range is free of pending writes |

## Verification
The bound checker watches several rules on every cycle. After any dispatch, the first bit it names must be pending; this covers same-cycle finishes as well. After a lone finish, its first bit must be clear. A pending in-range bit must never show a consumer as ready, in either mode. Bits past vlen must never block a consumer. The chaining schedule itself is a property of the whole operation sequence: per-bit mode ends the add slices in cycle 6 and whole-register mode ends them in cycle 10. Only the bench's replay of that sequence in both modes shows this, together with the corner scenarios for clipping, zero counts and merged ports, each compared against a behavioural model on every clock.

// File: rtl/mscb_pkg.sv
package mscb_pkg;
  typedef enum logic {
    TRACK_BIT   = 1'b0,
    TRACK_WHOLE = 1'b1
  } track_e;
endpackage

// File: rtl/mscb_range_dec.sv
// Turns a (start, count) pair into a bit mask of width W; bits past W-1 fall away.
module mscb_range_dec #(
  parameter int W = 64,
  localparam int SW = $clog2(W),
  localparam int CW = SW + 1
) (
  input  logic [SW-1:0] start,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  mask
);
  always_comb begin
    int lo;
    int hi;
    lo = int'(start);
    hi = lo + int'(cnt);
    for (int i = 0; i < W; i++) begin
      mask[i] = (i >= lo) && (i < hi);
    end
  end
endmodule

// File: rtl/mscb_pend_row.sv
// One pending vector: clear is applied before set, so a same-cycle dispatch wins.
module mscb_pend_row #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_m) | set_m;
  end
endmodule

// File: rtl/mscb_query.sv
// Readiness of one consumer query against the stored pending vectors.
module mscb_query
  import mscb_pkg::*;
#(
  parameter int W    = 64,
  parameter int NREG = 4,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG-1:0][W-1:0] pend,
  input  logic [RW-1:0]          sel,
  input  logic [W-1:0]           range_m,
  input  logic [W-1:0]           vl_m,
  input  logic                   whole_mode,
  output logic                   ready
);
  logic [W-1:0] row;
  track_e       mode;

  always_comb begin
    row  = pend[sel];
    mode = track_e'(whole_mode);
    if (mode == TRACK_WHOLE) ready = (row == '0);
    else                     ready = ((row & range_m & vl_m) == '0);
  end
endmodule

// File: rtl/mask_chain_scoreboard.sv
module mask_chain_scoreboard #(
  parameter int W    = 64,
  parameter int NREG = 4,
  parameter int NISS = 2,
  parameter int NCMP = 2,
  parameter int NQ   = 3,
  localparam int SW  = $clog2(W),
  localparam int CW  = SW + 1,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     whole_mode,
  input  logic [CW-1:0]            vlen,
  input  logic [NISS-1:0]          iss_valid,
  input  logic [NISS-1:0][RW-1:0]  iss_reg,
  input  logic [NISS-1:0][SW-1:0]  iss_start,
  input  logic [NISS-1:0][CW-1:0]  iss_cnt,
  input  logic [NCMP-1:0]          cmp_valid,
  input  logic [NCMP-1:0][RW-1:0]  cmp_reg,
  input  logic [NCMP-1:0][SW-1:0]  cmp_start,
  input  logic [NCMP-1:0][CW-1:0]  cmp_cnt,
  input  logic [NQ-1:0][RW-1:0]    q_reg,
  input  logic [NQ-1:0][SW-1:0]    q_start,
  input  logic [NQ-1:0][CW-1:0]    q_cnt,
  output logic [NQ-1:0]            q_ready
);
  logic [NISS-1:0][W-1:0] iss_m;
  logic [NCMP-1:0][W-1:0] cmp_m;
  logic [NQ-1:0][W-1:0]   q_m;
  logic [W-1:0]           vl_m;
  logic [NREG-1:0][W-1:0] set_r;
  logic [NREG-1:0][W-1:0] clr_r;
  logic [NREG-1:0][W-1:0] pend_q;

  mscb_range_dec #(.W(W)) u_vl_dec (.start('0), .cnt(vlen), .mask(vl_m));

  for (genvar p = 0; p < NISS; p++) begin : g_iss
    mscb_range_dec #(.W(W)) u_dec (
      .start(iss_start[p]), .cnt(iss_cnt[p]), .mask(iss_m[p]));
  end

  for (genvar p = 0; p < NCMP; p++) begin : g_cmp
    mscb_range_dec #(.W(W)) u_dec (
      .start(cmp_start[p]), .cnt(cmp_cnt[p]), .mask(cmp_m[p]));
  end

  // Merge every port aimed at each register.
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      set_r[r] = '0;
      clr_r[r] = '0;
      for (int p = 0; p < NISS; p++) begin
        if (iss_valid[p] && (iss_reg[p] == RW'(r))) set_r[r] = set_r[r] | iss_m[p];
      end
      for (int p = 0; p < NCMP; p++) begin
        if (cmp_valid[p] && (cmp_reg[p] == RW'(r))) clr_r[r] = clr_r[r] | cmp_m[p];
      end
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_row
    mscb_pend_row #(.W(W)) u_row (
      .clk(clk), .rst_n(rst_n), .set_m(set_r[r]), .clr_m(clr_r[r]), .pend(pend_q[r]));
  end

  for (genvar i = 0; i < NQ; i++) begin : g_q
    mscb_range_dec #(.W(W)) u_dec (
      .start(q_start[i]), .cnt(q_cnt[i]), .mask(q_m[i]));
    mscb_query #(.W(W), .NREG(NREG)) u_qry (
      .pend(pend_q), .sel(q_reg[i]), .range_m(q_m[i]), .vl_m(vl_m),
      .whole_mode(whole_mode), .ready(q_ready[i]));
  end
endmodule

// File: rtl/mscb_chk.sv
module mscb_chk #(
  parameter int W    = 64,
  parameter int NREG = 4,
  parameter int NISS = 2,
  parameter int NCMP = 2,
  parameter int NQ   = 3,
  localparam int SW  = $clog2(W),
  localparam int CW  = SW + 1,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     whole_mode,
  input logic [CW-1:0]            vlen,
  input logic [NISS-1:0]          iss_valid,
  input logic [NISS-1:0][RW-1:0]  iss_reg,
  input logic [NISS-1:0][SW-1:0]  iss_start,
  input logic [NISS-1:0][CW-1:0]  iss_cnt,
  input logic [NCMP-1:0]          cmp_valid,
  input logic [NCMP-1:0][RW-1:0]  cmp_reg,
  input logic [NCMP-1:0][SW-1:0]  cmp_start,
  input logic [NCMP-1:0][CW-1:0]  cmp_cnt,
  input logic [NQ-1:0][RW-1:0]    q_reg,
  input logic [NQ-1:0][SW-1:0]    q_start,
  input logic [NQ-1:0][CW-1:0]    q_cnt,
  input logic [NQ-1:0]            q_ready,
  input logic [NREG-1:0][W-1:0]   pend_q
);
  for (genvar p = 0; p < NISS; p++) begin : g_iss_chk
    logic          sv;
    logic [RW-1:0] sr;
    logic [SW-1:0] ss;
    always_ff @(posedge clk) begin
      if (!rst_n) sv <= 1'b0;
      else        sv <= iss_valid[p] && (iss_cnt[p] != '0);
      sr <= iss_reg[p];
      ss <= iss_start[p];
    end
    // R2 R4
    issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sv |-> pend_q[sr][ss]);
  end

  for (genvar p = 0; p < NCMP; p++) begin : g_cmp_chk
    logic          sv;
    logic [RW-1:0] sr;
    logic [SW-1:0] ss;
    always_ff @(posedge clk) begin
      if (!rst_n) sv <= 1'b0;
      else        sv <= cmp_valid[p] && (cmp_cnt[p] != '0) && (iss_valid == '0);
      sr <= cmp_reg[p];
      ss <= cmp_start[p];
    end
    // R3
    finish_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sv |-> !pend_q[sr][ss]);
  end

  for (genvar i = 0; i < NQ; i++) begin : g_q_chk
    // R7
    whole_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (whole_mode && (pend_q[q_reg[i]] != '0)) |-> !q_ready[i]);
    // R5
    bit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!whole_mode && (q_cnt[i] != '0) && (CW'(q_start[i]) < vlen) &&
       pend_q[q_reg[i]][q_start[i]]) |-> !q_ready[i]);
    // R6
    past_vlen_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!whole_mode && (CW'(q_start[i]) >= vlen) &&
       ((CW'(q_start[i]) + q_cnt[i]) <= CW'(W))) |-> q_ready[i]);
  end
endmodule

bind mask_chain_scoreboard mscb_chk #(
  .W(W), .NREG(NREG), .NISS(NISS), .NCMP(NCMP), .NQ(NQ)
) u_mscb_chk (
  .clk(clk), .rst_n(rst_n), .whole_mode(whole_mode), .vlen(vlen),
  .iss_valid(iss_valid), .iss_reg(iss_reg), .iss_start(iss_start), .iss_cnt(iss_cnt),
  .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_start(cmp_start), .cmp_cnt(cmp_cnt),
  .q_reg(q_reg), .q_start(q_start), .q_cnt(q_cnt), .q_ready(q_ready), .pend_q(pend_q));

// File: tb/test_mask_chain_scoreboard.sv
module test_mask_chain_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64, NREG = 4, NISS = 2, NCMP = 2, NQ = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic whole_mode = 1'b0;
  logic [6:0] vlen = 7'd20;
  logic [NISS-1:0] iss_valid;
  logic [NISS-1:0][1:0] iss_reg;
  logic [NISS-1:0][5:0] iss_start;
  logic [NISS-1:0][6:0] iss_cnt;
  logic [NCMP-1:0] cmp_valid;
  logic [NCMP-1:0][1:0] cmp_reg;
  logic [NCMP-1:0][5:0] cmp_start;
  logic [NCMP-1:0][6:0] cmp_cnt;
  logic [NQ-1:0][1:0] q_reg;
  logic [NQ-1:0][5:0] q_start;
  logic [NQ-1:0][6:0] q_cnt;
  logic [NQ-1:0] q_ready;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit ref_ok = 0;
  bit ref_pend [NREG][W];
  int fp_cyc [5];
  int ac_cyc [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_chain_scoreboard i_mask_chain_scoreboard (
    .clk(clk), .rst_n(rst_n), .whole_mode(whole_mode), .vlen(vlen),
    .iss_valid(iss_valid), .iss_reg(iss_reg), .iss_start(iss_start), .iss_cnt(iss_cnt),
    .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .cmp_start(cmp_start), .cmp_cnt(cmp_cnt),
    .q_reg(q_reg), .q_start(q_start), .q_cnt(q_cnt), .q_ready(q_ready));

  // Behavioural reference: per-bit flags, finishes first, then dispatches.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) for (int b = 0; b < W; b++) ref_pend[r][b] = 1'b0;
    end else begin
      for (int p = 0; p < NCMP; p++)
        if (cmp_valid[p])
          for (int b = int'(cmp_start[p]); b < int'(cmp_start[p]) + int'(cmp_cnt[p]) && b < W; b++)
            ref_pend[cmp_reg[p]][b] = 1'b0;
      for (int p = 0; p < NISS; p++)
        if (iss_valid[p])
          for (int b = int'(iss_start[p]); b < int'(iss_start[p]) + int'(iss_cnt[p]) && b < W; b++)
            ref_pend[iss_reg[p]][b] = 1'b1;
    end
  end

  function automatic bit ref_ready(int i);
    bit rdy = 1'b1;
    for (int b = 0; b < W; b++) begin
      if (ref_pend[q_reg[i]][b]) begin
        if (whole_mode) rdy = 1'b0;
        else if (b >= int'(q_start[i]) && b < int'(q_start[i]) + int'(q_cnt[i]) && b < int'(vlen))
          rdy = 1'b0;
      end
    end
    return rdy;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every clock: each query output against the model (R5 in per-bit, R7 in whole mode).
  always @(negedge clk) begin
    if (rst_n && ref_ok)
      for (int i = 0; i < NQ; i++)
        check(whole_mode ? "R7 model" : "R5 model", int'(q_ready[i]), int'(ref_ready(i)));
  end

  task automatic idle();
    iss_valid = '0; cmp_valid = '0;
    iss_reg = '0; iss_start = '0; iss_cnt = '0;
    cmp_reg = '0; cmp_start = '0; cmp_cnt = '0;
  endtask

  task automatic set_q(int i, int r, int s, int n);
    q_reg[i] = 2'(r); q_start[i] = 6'(s); q_cnt[i] = 7'(n);
  endtask

  task automatic do_iss(int p, int r, int s, int n);
    iss_valid[p] = 1'b1; iss_reg[p] = 2'(r); iss_start[p] = 6'(s); iss_cnt[p] = 7'(n);
  endtask

  task automatic do_cmp(int p, int r, int s, int n);
    cmp_valid[p] = 1'b1; cmp_reg[p] = 2'(r); cmp_start[p] = 6'(s); cmp_cnt[p] = 7'(n);
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    set_q(0, 0, 0, 64); set_q(1, 2, 0, 64); set_q(2, 3, 0, 64);
    #1;
    // R1
    for (int i = 0; i < NQ; i++) check("R1 reset ready", int'(q_ready[i]), 1);
  endtask

  // Registers: 0 = compare result, 1 = second mask, 2 = combined mask.
  task automatic run_chain(input bit whole);
    int a = 0, f = 0;
    whole_mode = whole; vlen = 7'd20;
    do_reset();
    tick(); do_iss(0, 0, 0, 20); do_iss(1, 2, 0, 20);
    for (int c = 0; c < 30 && f < 5; c++) begin
      tick();
      if (c < 5) do_cmp(0, 0, 4 * c, 4);
      set_q(0, 0, 4 * (a % 5), 4); set_q(1, 1, 4 * (a % 5), 4); set_q(2, 2, 4 * (f % 5), 4);
      #1;
      if (a < 5 && q_ready[0] && q_ready[1]) begin
        if (whole) begin
          do_cmp(1, 2, 0, 64);
          for (int k = 0; k < 5; k++) ac_cyc[k] = c;
          a = 5;
        end else begin
          do_cmp(1, 2, 4 * a, 4); ac_cyc[a] = c; a++;
        end
      end
      if (f < 5 && q_ready[2]) begin fp_cyc[f] = c; f++; end
    end
    tick();
    check("R9 all slices ran", f, 5);
    for (int k = 0; k < 5; k++) begin
      // R9
      check(whole ? "R9 whole-register add cycle" : "R9 per-bit add cycle",
            fp_cyc[k], whole ? 6 + k : 2 + k);
      check("R9 add after combine", int'(fp_cyc[k] > ac_cyc[k]), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(); set_q(0, 0, 0, 4); set_q(1, 0, 0, 4); set_q(2, 0, 0, 4);
    ref_ok = 1;
    run_chain(1'b0);
    run_chain(1'b1);

    // Corner cases in per-bit mode with vlen = 20.
    whole_mode = 1'b0; vlen = 7'd20;
    do_reset();
    tick(); do_iss(0, 3, 0, 8);
    tick(); do_iss(0, 3, 0, 8); do_cmp(0, 3, 0, 8);
    tick(); set_q(0, 3, 0, 8); #1;
    check("R4 dispatch wins over finish", int'(q_ready[0]), 0);
    do_cmp(0, 3, 0, 8);
    tick(); #1;
    check("R3 finish clears", int'(q_ready[0]), 1);
    do_iss(0, 3, 16, 16);
    tick(); set_q(0, 3, 20, 8); set_q(1, 3, 16, 4); set_q(2, 3, 0, 16); #1;
    check("R6 bits past vlen ready", int'(q_ready[0]), 1);
    check("R5 pending in range blocks", int'(q_ready[1]), 0);
    check("R5 disjoint range ready", int'(q_ready[2]), 1);
    whole_mode = 1'b1; #1;
    check("R7 whole mode blocks", int'(q_ready[2]), 0);
    whole_mode = 1'b0; vlen = 7'd64;
    do_iss(0, 1, 60, 10); do_iss(1, 2, 0, 0);
    tick(); set_q(0, 1, 63, 1); set_q(1, 2, 0, 4); set_q(2, 1, 56, 4); #1;
    check("R2 clipped range sets top bit", int'(q_ready[0]), 0);
    check("R2 zero count sets nothing", int'(q_ready[1]), 1);
    check("R2 bits below start untouched", int'(q_ready[2]), 1);
    do_cmp(0, 1, 60, 4); do_cmp(1, 3, 16, 16); do_iss(0, 0, 8, 2); do_iss(1, 0, 12, 2);
    tick(); set_q(0, 1, 60, 4); set_q(1, 3, 16, 16); set_q(2, 0, 8, 6); #1;
    check("R8 two finishes", int'(q_ready[0] & q_ready[1]), 1);
    check("R8 two dispatches same register", int'(q_ready[2]), 0);
    set_q(2, 0, 10, 2); #1;
    check("R8 gap between merged ranges", int'(q_ready[2]), 1);
    tick(); tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule